// File: doc/BRIEF.md
# Periodic Second Drop/Repeat Trimmer

This block sits next to a real-time seconds counter and removes long-term drift by acting on whole seconds, not on the oscillator. It takes the raw one-second tick and turns each one into an increment request of 0, 1 or 2 seconds for the counter. When correction is enabled, one tick in every (period + 1) ticks is corrected. A correction either drops that second, so the request is 0, or repeats it, so the request is 2. A period value of N sets a rate of 1e9/(N+1) parts per billion.

The block is set up through one 32-bit control word, written with a one-cycle write strobe. A write loads the period, the direction code and the enable bit. It also restarts the internal interval count, so the phase of the correction follows every update of the word.

Top module: `sec_trim`

## Requirements
- R1: After reset the increment request `step_o` is 0 and correction is disabled, so each tick produces a request of 1.
- R2: In a cycle that follows a cycle with `tick_i` low, `step_o` is 0.
- R3: The request for a tick appears on `step_o` in the clock cycle after `tick_i` is high, and it lasts exactly one cycle.
- R4: When the enable bit (bit 23 of the control word) is 0, every tick gives a request of 1, whatever the other fields hold.
- R5: When the enable bit is set and the direction code (bits 20:19) is 0 or 1, every tick gives a request of 1.
- R6: With direction code 2 (drop) and period P (bits 18:0), ticks 1 to P after a write give 1 and tick P+1 gives 0. The pattern then repeats every P+1 ticks.
- R7: With direction code 3 (repeat), the corrected tick gives a request of 2, with the same spacing as in R6.
- R8: With P = 0 and correction enabled, every tick is corrected.
- R9: A write of the control word restarts the interval count. A tick in the same cycle as the write gives a request of 1 and does not count toward the new interval.
- R10: Bits 21, 22 and 24 to 31 of the control word have no effect on the requests.
- R11: `step_o` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per raw second |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word: period 18:0, direction 20:19, enable 23 |
| step_o | output | 2 | Seconds to add for the previous cycle's tick (0, 1 or 2) |

## Verification
The bench targets the phase of the correction: the first corrected tick after a write, back-to-back corrections with P = 0, and a tick that lands in the same cycle as a write. An off-by-one counter would correct after P or P+2 ticks. A design that let a write-cycle tick count would move every later correction one tick earlier. It also checks that direction codes 0 and 1 and junk bits outside the fields change nothing, because a design that decodes only the enable bit, or reads the wrong bit range, would drop or repeat seconds that it should pass through unchanged.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;
   typedef enum logic [1:0] {
      TRIM_NONE_A = 2'd0,
      TRIM_NONE_B = 2'd1,
      TRIM_DROP   = 2'd2,
      TRIM_REPEAT = 2'd3
   } trim_dir_e;

   localparam logic [1:0] STEP_ZERO   = 2'd0;
   localparam logic [1:0] STEP_ONE    = 2'd1;
   localparam logic [1:0] STEP_DOUBLE = 2'd2;
endpackage

// File: rtl/sec_trim_cfg.sv
module sec_trim_cfg
   import sec_trim_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PER_W     = 19,
   parameter int DIR_LSB   = 19,
   parameter int VALID_POS = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              active_o,
   output logic              drop_o,
   output logic [PER_W-1:0]  period_o
);
   localparam int DIR_MSB = DIR_LSB + 1;

   initial begin
      if (PER_W > DIR_LSB) $error("period field overlaps direction field");
      if (DIR_MSB >= VALID_POS) $error("direction field overlaps enable bit");
      if (VALID_POS >= DATA_W) $error("enable bit outside control word");
   end

   logic             valid_q;
   trim_dir_e        dir_q;
   logic [PER_W-1:0] per_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         dir_q   <= TRIM_NONE_A;
         per_q   <= '0;
      end else if (we_i) begin
         valid_q <= wdata_i[VALID_POS];
         dir_q   <= trim_dir_e'(wdata_i[DIR_MSB:DIR_LSB]);
         per_q   <= wdata_i[PER_W-1:0];
      end
   end

   always_comb begin
      active_o = valid_q && (dir_q == TRIM_DROP || dir_q == TRIM_REPEAT);
      drop_o   = (dir_q == TRIM_DROP);
      period_o = per_q;
   end
endmodule

// File: rtl/sec_trim_interval.sv
module sec_trim_interval #(
   parameter int PER_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             active_i,
   input  logic [PER_W-1:0] period_i,
   output logic             hit_o
);
   logic [PER_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == period_i);
   assign hit_o  = tick_i && active_i && !clr_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr_i || !active_i) cnt_q <= '0;
      else if (tick_i)             cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R6
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> cnt_q <= period_i);

   // R9
   wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sec_trim.sv
module sec_trim
   import sec_trim_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PER_W     = 19,
   parameter int DIR_LSB   = 19,
   parameter int VALID_POS = 23,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              cfg_we_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [1:0]        step_o
);
   logic             active;
   logic             drop;
   logic [PER_W-1:0] period;
   logic             hit;
   logic [1:0]       step_d;

   sec_trim_cfg #(
      .DATA_W(DATA_W), .PER_W(PER_W), .DIR_LSB(DIR_LSB), .VALID_POS(VALID_POS)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
      .active_o(active), .drop_o(drop), .period_o(period)
   );

   sec_trim_interval #(.PER_W(PER_W)) u_ivl (
      .clk(clk), .rst_n(rst_n), .clr_i(cfg_we_i), .tick_i(tick_i),
      .active_i(active), .period_i(period), .hit_o(hit)
   );

   always_comb begin
      if (!tick_i)   step_d = STEP_ZERO;
      else if (!hit) step_d = STEP_ONE;
      else           step_d = drop ? STEP_ZERO : STEP_DOUBLE;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [1:0] step_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) step_q <= STEP_ZERO;
            else        step_q <= step_d;
         end
         assign step_o = step_q;

         // R2
         idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_i |=> step_o == STEP_ZERO);

         // R4
         off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_i && !active) |=> step_o == STEP_ONE);
      end else begin : g_comb
         assign step_o = step_d;
      end
   endgenerate

   // R11
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_o != 2'd3);
endmodule

// File: tb/sec_trim_tb.sv
module sec_trim_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [31:0] cfg_wdata_i = '0;
   logic [1:0]  step_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // model state
   bit          m_valid = 0;
   int          m_dir = 0;
   int          m_per = 0;
   int          m_cnt = 0;

   always #4 clk = ~clk;

   sec_trim u_dut (.*);

   function automatic bit m_active();
      return m_valid && (m_dir >= 2);
   endfunction

   function automatic int m_step();
      if (!m_active()) return 1;
      if (m_cnt == m_per) begin
         m_cnt = 0;
         return (m_dir == 2) ? 0 : 2;
      end
      m_cnt++;
      return 1;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: step_o=%0d expected %0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_tick(input string req);
      int e;
      @(negedge clk); tick_i = 1'b1;
      e = m_step();
      @(negedge clk); tick_i = 1'b0;
      chk(req, step_o, e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R2", step_o, 0);
      end
   endtask

   task automatic wr(input bit v, input int dir, input int per, input bit junk,
                     input bit with_tick);
      logic [31:0] w;
      w = '0;
      w[23] = v; w[20:19] = dir[1:0]; w[18:0] = per[18:0];
      if (junk) begin
         w[31:24] = $urandom; w[22:21] = $urandom;
      end
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_wdata_i = w; tick_i = with_tick;
      @(negedge clk);
      cfg_we_i = 1'b0; tick_i = 1'b0;
      if (with_tick) chk("R9", step_o, 1);
      m_valid = v; m_dir = dir; m_per = per; m_cnt = 0;
   endtask

   initial begin
      while (cycles < 200000) begin
         @(posedge clk); cycles++;
      end
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      chk("R1", step_o, 0);
      rst_n = 1'b1;
      idle(2);
      for (int i = 0; i < 3; i++) do_tick("R1");

      // R3: one cycle wide
      do_tick("R3");
      @(negedge clk); chk("R3", step_o, 0);

      // R4: disabled with drop direction
      wr(0, 2, 0, 0, 0);
      for (int i = 0; i < 4; i++) do_tick("R4");
      // R5: codes 0 and 1
      wr(1, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) do_tick("R5");
      wr(1, 1, 1, 0, 0);
      for (int i = 0; i < 3; i++) do_tick("R5");
      // R8: period 0
      wr(1, 2, 0, 0, 0);
      for (int i = 0; i < 3; i++) do_tick("R8");
      wr(1, 3, 0, 0, 0);
      for (int i = 0; i < 3; i++) do_tick("R8");
      // R6 / R7 directed
      wr(1, 2, 3, 0, 0);
      for (int i = 0; i < 9; i++) do_tick("R6");
      wr(1, 3, 40, 0, 0);
      for (int i = 0; i < 84; i++) do_tick("R7");
      // R9: write mid-interval, tick on write cycle
      wr(1, 2, 2, 0, 0);
      do_tick("R9"); do_tick("R9");
      wr(1, 2, 2, 0, 1);
      for (int i = 0; i < 4; i++) do_tick("R9");
      // R10: junk bits
      wr(0, 3, 0, 1, 0);
      for (int i = 0; i < 3; i++) do_tick("R10");
      wr(1, 3, 1, 1, 0);
      for (int i = 0; i < 5; i++) do_tick("R10");

      // random mix
      for (int r = 0; r < 40; r++) begin
         wr($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 5),
            $urandom_range(0, 1), $urandom_range(0, 3) == 0);
         for (int k = 0; k < 12; k++) begin
            do_tick((m_dir == 3) ? "R7" : "R6");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule